// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Bit-Clock Generation

This block drives a three-wire serial audio link as the clock owner. From the system clock it derives a continuously running bit clock and a word-select clock. It then shifts a stereo pair of signed PCM samples out on one data line, sending the left channel while word select is low and the right channel while it is high. A sample pair is handed over on a valid/ready handshake and buffered for the frame that follows. If no pair is waiting when a frame begins, the frame carries silence and a one-cycle underrun pulse is raised.

The sample width and the slot width are set independently. A narrow sample can therefore sit in a wider slot, for example sixteen data bits in a 32-bit slot, which gives a bit clock of 64 times the sample rate. The sample is placed either at the start of its slot or at its end, and the unused bits are zero. Word select can lead the first data bit by one bit clock, which is the standard timing, or it can change together with that bit. All settings are taken at frame starts, so a frame on the wire never mixes two configurations.

Top module: `i2s_tx_master`

## Requirements
- R1: `bclk_o` is low out of reset. While running, each bit-clock period is exactly 2 × `bclk_div_i` system cycles, with equal high and low halves (a value of 0 counts as 1).
- R2: A frame is 2 × slot-width bit clocks long. The left slot comes first with word select 0 and the right slot follows with word select 1, so word select spends exactly half of each frame high.
- R3: With `ws_aligned_i` = 0, word select changes on the bit clock before the first bit of each slot. It falls during the last right-slot bit and rises during the last left-slot bit.
- R4: With `ws_aligned_i` = 1, word select changes in the same bit clock as the first bit of each slot.
- R5: Samples are MSB-justified in the 24-bit `left_i`/`right_i` fields and are sent most significant bit first. Only the top `smp_bits_i` bits are sent. Lower input bits have no effect on `sd_o`.
- R6: With `right_just_i` = 0, the sample fills the first `smp_bits_i` bits of the slot and the rest of the slot is 0.
- R7: With `right_just_i` = 1, the sample fills the last `smp_bits_i` bits of the slot and the leading bits are 0.
- R8: `ws_o` and `sd_o` change only in the system cycle in which `bclk_o` falls, so a receiver can sample them on the rising edge.
- R9: One sample pair is buffered. `pair_ready_o` is low in the cycle after a pair is accepted, and it stays low until a frame start takes that pair.
- R10: A frame that starts with no buffered pair sends zeros in both slots, and `underrun_o` pulses high for one cycle at that frame start.
- R11: The divider, widths, justification and timing mode are sampled only at frame starts. A change in mid-frame first affects the next frame.
- R12: During and after reset, `ws_o`, `sd_o` and `underrun_o` are 0 and `pair_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_div_i | input | DIV_W | System cycles per bit-clock half period |
| smp_bits_i | input | 5 | Sample width in bits, 1 to 24 |
| slot_bits_i | input | 6 | Slot width in bits, sample width to 32 |
| right_just_i | input | 1 | 0: sample at the start of the slot, 1: sample at the end of the slot |
| ws_aligned_i | input | 1 | 0: word select leads by one bit, 1: word select changes with the first bit |
| pair_valid_i | input | 1 | A sample pair is offered |
| pair_ready_o | output | 1 | The buffer can take a pair |
| left_i | input | SAMPLE_W | Left sample, MSB-justified, two's complement |
| right_i | input | SAMPLE_W | Right sample, MSB-justified, two's complement |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 for left and 1 for right |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse when a frame starts without data |

## Verification
A wrong bit position or slot counter shows up within one frame at the ports. Data bits appear shifted against word select, the word-select edges fall one bit early or late, or the frame length no longer matches 2 × slot width. A wrong divider count changes the spacing of the next bit-clock edge. A stale or lost buffer flag produces a silent frame, or repeats an old pair, in the very next frame, together with a missing or extra underrun pulse. A configuration latched at the wrong time alters the frame in which the inputs changed rather than the one after it.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  typedef enum logic {JUST_START = 1'b0, JUST_END = 1'b1} just_e;
  typedef enum logic {WS_LEAD = 1'b0, WS_WITH = 1'b1} ws_mode_e;

  typedef struct packed {
    just_e    just;
    ws_mode_e ws_mode;
  } fmt_cfg_t;
endpackage

// File: rtl/i2s_bclk_div.sv
module i2s_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             bclk_o,
  output logic             fall_o
);
  logic             started_q, bclk_q, tick;
  logic [DIV_W-1:0] div_q, cnt_q, cur_div, lim;

  // live divider only until the first frame has latched one
  assign cur_div = started_q ? div_q : div_i;
  assign lim     = (cur_div == '0) ? '0 : cur_div - DIV_W'(1);
  assign tick    = (cnt_q >= lim);
  assign fall_o  = tick & bclk_q;
  assign bclk_o  = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      bclk_q    <= 1'b0;
      div_q     <= '0;
      started_q <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
      if (load_i) begin
        div_q     <= div_i;
        started_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2s_pair_buf.sv
module i2s_pair_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  input  logic                take_i,
  output logic                full_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic                full_q, accept;
  logic [SAMPLE_W-1:0] left_q, right_q;

  assign ready_o = ~full_q;
  assign accept  = valid_i & ~full_q;
  assign full_o  = full_q;
  assign left_o  = left_q;
  assign right_o = right_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      full_q <= accept | (full_q & ~take_i);
      if (accept) begin
        left_q  <= left_i;
        right_q <= right_i;
      end
    end
  end

  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o); // R9
endmodule

// File: rtl/i2s_frame_ser.sv
module i2s_frame_ser
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_MAX = 32,
  localparam int SMP_BW  = $clog2(SAMPLE_W + 1),
  localparam int SLOT_BW = $clog2(SLOT_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  logic [SMP_BW-1:0]   smp_bits_i,
  input  logic [SLOT_BW-1:0]  slot_bits_i,
  input  fmt_cfg_t            cfg_i,
  input  logic                have_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                frame_start_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  localparam int PW = SLOT_BW + 1;

  logic                started_q, ws_q, sd_q, und_q;
  logic [PW-1:0]       pos_q;
  logic [SMP_BW-1:0]   smp_q;
  logic [SLOT_BW-1:0]  slot_q;
  fmt_cfg_t            cfg_q;
  logic [SAMPLE_W-1:0] l_q, r_q;

  logic                frame_start, right_ch, in_win, n_ws, n_sd;
  logic [PW-1:0]       n_pos, n_slot_e, b, off, rel, nxt;
  logic [SMP_BW-1:0]   n_smp;
  logic [SLOT_BW-1:0]  n_slot;
  fmt_cfg_t            n_cfg;
  logic [SAMPLE_W-1:0] n_l, n_r, word, shv;

  always_comb begin
    frame_start = fall_i & (~started_q | (pos_q == (PW'(slot_q) << 1) - PW'(1)));
    if (frame_start) begin
      n_pos  = '0;
      n_slot = slot_bits_i;
      n_smp  = smp_bits_i;
      n_cfg  = cfg_i;
      n_l    = have_i ? left_i  : '0;
      n_r    = have_i ? right_i : '0;
    end else begin
      n_pos  = pos_q + PW'(1);
      n_slot = slot_q;
      n_smp  = smp_q;
      n_cfg  = cfg_q;
      n_l    = l_q;
      n_r    = r_q;
    end
    n_slot_e = PW'(n_slot);
    right_ch = (n_pos >= n_slot_e);
    b        = right_ch ? n_pos - n_slot_e : n_pos;
    off      = (n_cfg.just == JUST_END) ? n_slot_e - PW'(n_smp) : '0;
    rel      = b - off;
    in_win   = (b >= off) && (rel < PW'(n_smp));
    word     = right_ch ? n_r : n_l;
    shv      = word << rel;
    n_sd     = in_win & shv[SAMPLE_W-1];
    nxt      = n_pos + PW'(1);
    if (n_cfg.ws_mode == WS_WITH) n_ws = right_ch;
    else if (nxt == (n_slot_e << 1)) n_ws = 1'b0;
    else n_ws = (nxt >= n_slot_e);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      pos_q     <= '0;
      smp_q     <= '0;
      slot_q    <= '0;
      cfg_q     <= '0;
      l_q       <= '0;
      r_q       <= '0;
      ws_q      <= 1'b0;
      sd_q      <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      und_q <= frame_start & ~have_i;
      if (fall_i) begin
        started_q <= 1'b1;
        pos_q     <= n_pos;
        smp_q     <= n_smp;
        slot_q    <= n_slot;
        cfg_q     <= n_cfg;
        l_q       <= n_l;
        r_q       <= n_r;
        ws_q      <= n_ws;
        sd_q      <= n_sd;
      end
    end
  end

  assign frame_start_o = frame_start;
  assign ws_o          = ws_q;
  assign sd_o          = sd_q;
  assign underrun_o    = und_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !frame_start) |=> ($stable(slot_q) && $stable(smp_q) && $stable(cfg_q))); // R11
  AST_UNDERRUN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_q |-> !sd_q); // R10
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_MAX = 32,
  localparam int SMP_BW  = $clog2(SAMPLE_W + 1),
  localparam int SLOT_BW = $clog2(SLOT_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    bclk_div_i,
  input  logic [SMP_BW-1:0]   smp_bits_i,
  input  logic [SLOT_BW-1:0]  slot_bits_i,
  input  logic                right_just_i,
  input  logic                ws_aligned_i,
  input  logic                pair_valid_i,
  output logic                pair_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  logic                fall, frame_start, have;
  logic [SAMPLE_W-1:0] buf_l, buf_r;
  fmt_cfg_t            cfg;

  assign cfg.just    = just_e'(right_just_i);
  assign cfg.ws_mode = ws_mode_e'(ws_aligned_i);

  i2s_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (bclk_div_i),
    .load_i (frame_start),
    .bclk_o (bclk_o),
    .fall_o (fall)
  );

  i2s_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pair_valid_i),
    .ready_o (pair_ready_o),
    .left_i  (left_i),
    .right_i (right_i),
    .take_i  (frame_start),
    .full_o  (have),
    .left_o  (buf_l),
    .right_o (buf_r)
  );

  i2s_frame_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_MAX(SLOT_MAX)) u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fall_i        (fall),
    .smp_bits_i    (smp_bits_i),
    .slot_bits_i   (slot_bits_i),
    .cfg_i         (cfg),
    .have_i        (have),
    .left_i        (buf_l),
    .right_i       (buf_r),
    .frame_start_o (frame_start),
    .ws_o          (ws_o),
    .sd_o          (sd_o),
    .underrun_o    (underrun_o)
  );

  AST_WS_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_o != $past(ws_o)) |-> (!bclk_o && $past(bclk_o))); // R8
  AST_SD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_o != $past(sd_o)) |-> (!bclk_o && $past(bclk_o))); // R8
  AST_UNDERRUN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o); // R10
  AST_UNDERRUN_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (!bclk_o && $past(bclk_o))); // R10
endmodule

// File: tb/i2s_tx_master_test.sv
module i2s_tx_master_test;
  localparam int DIV_W = 8;
  localparam int SW    = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    div = 8'd1;
  logic [4:0]    smp_bits = 5'd16;
  logic [5:0]    slot_bits = 6'd32;
  logic          rj = 1'b0, al = 1'b0, valid = 1'b0;
  logic [SW-1:0] l_in = '0, r_in = '0;
  logic          ready, bclk, ws, sd, und;

  i2s_tx_master #(.DIV_W(DIV_W), .SAMPLE_W(SW), .SLOT_MAX(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_div_i(div), .smp_bits_i(smp_bits),
    .slot_bits_i(slot_bits), .right_just_i(rj), .ws_aligned_i(al),
    .pair_valid_i(valid), .pair_ready_o(ready), .left_i(l_in), .right_i(r_in),
    .bclk_o(bclk), .ws_o(ws), .sd_o(sd), .underrun_o(und));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, cap_n = 0, und_cnt = 0, last_rise = -1, per_min = 0, per_max = 0;
  bit mon_en = 0, rise_seen = 0, prev_bclk = 0;
  logic cap_ws [0:511];
  logic cap_sd [0:511];

  logic [SW-1:0] f_l [0:7];
  logic [SW-1:0] f_r [0:7];
  bit            f_has [0:7];
  int            f_smp [0:7];
  int            f_slot [0:7];
  bit            f_rj [0:7];
  bit            f_al [0:7];

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (bclk && !prev_bclk) begin
        if (last_rise >= 0) begin
          if (per_min == 0 || cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (rise_seen) begin
          if (cap_n < 512) begin
            cap_ws[cap_n] = ws;
            cap_sd[cap_n] = sd;
          end
          cap_n++;
        end
        rise_seen = 1;
      end
      if (und) und_cnt++;
    end
    prev_bclk = bclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  // nfr frames, npr pairs fed; chg: config B applied during frame 0
  task automatic run(input int sm, input int sl, input bit r, input bit a, input int dv,
                     input int nfr, input int npr, input bit chg,
                     input int sm2, input int sl2, input bit r2, input bit a2, input int dv2,
                     input string tag);
    int total = 0;
    rst_n = 1'b0;
    valid = 1'b0;
    mon_en = 0;
    smp_bits = 5'(sm); slot_bits = 6'(sl); rj = r; al = a; div = 8'(dv);
    repeat (3) @(negedge clk);
    cap_n = 0; und_cnt = 0; last_rise = -1; per_min = 0; per_max = 0; rise_seen = 0;
    for (int f = 0; f < nfr; f++) begin
      f_l[f]   = SW'(f * 24'h3A5C71 + sm * 24'h01F2E3 + sl * 977 + 24'h5A5A5A);
      f_r[f]   = SW'(~f_l[f] ^ (f * 24'h0C3961 + dv * 24'h111111));
      f_has[f] = (f < npr);
      f_smp[f] = (chg && f > 0) ? sm2 : sm;
      f_slot[f] = (chg && f > 0) ? sl2 : sl;
      f_rj[f]  = (chg && f > 0) ? r2 : r;
      f_al[f]  = (chg && f > 0) ? a2 : a;
      total += 2 * f_slot[f];
    end
    rst_n = 1'b1;
    mon_en = 1;
    fork
      begin
        for (int p = 0; p < npr; p++) begin
          l_in = f_l[p];
          r_in = f_r[p];
          valid = 1'b1;
          while (!ready) @(negedge clk);
          @(negedge clk);
          valid = 1'b0;
        end
      end
      begin
        if (chg) begin
          wait (cap_n >= 3);
          @(negedge clk);
          smp_bits = 5'(sm2); slot_bits = 6'(sl2); rj = r2; al = a2; div = 8'(dv2);
        end
      end
      begin
        wait (cap_n >= total);
        mon_en = 0;
      end
    join
    begin
      int g = 0;
      for (int f = 0; f < nfr; f++) begin
        int bad = -1, act = 0, exv = 0;
        for (int p = 0; p < 2 * f_slot[f]; p++) begin
          int s = f_slot[f];
          bit ch = (p >= s);
          int bi = ch ? p - s : p;
          int off = f_rj[f] ? s - f_smp[f] : 0;
          logic [SW-1:0] smp = f_has[f] ? (ch ? f_r[f] : f_l[f]) : '0;
          bit eb = (bi >= off && bi < off + f_smp[f]) ? smp[SW-1-(bi-off)] : 1'b0;
          bit ew = f_al[f] ? ch : ((p + 1 == 2 * s) ? 1'b0 : (p + 1 >= s));
          if (bad < 0 && (cap_ws[g] !== ew || cap_sd[g] !== eb)) begin
            bad = p;
            act = {cap_ws[g], cap_sd[g]};
            exv = {ew, eb};
          end
          g++;
        end
        if (bad >= 0)
          $display("FAIL %s frame %0d bit %0d {ws,sd} actual=%0d expected=%0d", tag, f, bad, act, exv);
        checks++;
        if (bad >= 0) fails++;
      end
    end
    if (!chg)
      chk(per_min == 2 * dv && per_max == 2 * dv, {tag, " R1 period"}, per_max, 2 * dv);
    chk(und_cnt == nfr - npr, {tag, " R10 underrun pulses"}, und_cnt, nfr - npr);
  endtask

  initial begin
    // R12 reset state, R1 clock low out of reset
    div = 8'd10;
    repeat (2) @(negedge clk);
    chk(ready === 1'b1, "R12 ready in reset", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bclk === 1'b0, "R1 bclk low after reset", bclk, 0);
    chk(ws === 1'b0, "R12 ws after reset", ws, 0);
    chk(sd === 1'b0, "R12 sd after reset", sd, 0);
    chk(und === 1'b0, "R12 underrun after reset", und, 0);
    chk(ready === 1'b1, "R12 ready after reset", ready, 1);
    // R9 buffer full blocks further pairs
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(ready === 1'b0, "R9 ready low when buffer full", ready, 0);
    repeat (3) @(negedge clk);
    chk(ready === 1'b0, "R9 ready stays low before frame start", ready, 0);

    // sweep: R2 R3 R4 R5 R6 R7
    begin
      int k = 0;
      for (int si = 0; si < 3; si++) begin
        int sm = (si == 0) ? 1 : (si == 1) ? 12 : 24;
        for (int li = 0; li < 2; li++) begin
          int sl = (li == 0) ? sm : 32;
          for (int ri = 0; ri < 2; ri++)
            for (int ai = 0; ai < 2; ai++) begin
              run(sm, sl, bit'(ri), bit'(ai), 1 + (k % 3), 3, 3, 0, 0, 0, 0, 0, 0,
                  ai != 0 ? (ri != 0 ? "R2 R4 R5 R7" : "R2 R4 R5 R6")
                          : (ri != 0 ? "R2 R3 R5 R7" : "R2 R3 R5 R6"));
              k++;
            end
        end
      end
    end

    // R10 underrun: two pairs for four frames
    run(16, 32, 0, 0, 1, 4, 2, 0, 0, 0, 0, 0, 0, "R10 silent frames");
    // R11 mid-frame config change takes effect next frame
    run(16, 16, 0, 0, 2, 3, 3, 1, 24, 32, 1, 1, 1, "R11 config at frame start");
    run(8, 32, 1, 1, 3, 3, 3, 1, 20, 24, 0, 0, 2, "R11 config back to leading ws");

    finish_run();
  end
endmodule